// File: doc/BRIEF.md
# Sectioned Boot Image Loader

This block turns a stream of 32-bit words, such as those delivered by a serial receiver during boot, into memory writes. A fixed number of leading header words is thrown away first. After that the stream is a chain of sections. Each section is a word count, then a start address, then that many data words. The loader writes each data word to the next address, counting up from the start address. A section whose count is zero ends the load.

Words arrive on a valid/ready handshake. Writes leave on a registered address/data/strobe port, and the memory can hold a write in place with a wait input. Completion is reported on a level `done_o`. A separate sticky `err_o` reports any write that lands in a small reserved address window, which the boot code keeps for its own stack.

Top module: `bsl_boot_loader`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `err_o` are 0 and `word_ready_o` is 1.
- R2: The first SKIP_WORDS accepted words (default 2) are discarded. They cause no write and are never taken as a length, even when their value is zero.
- R3: After the header, an accepted word is a section length. The next accepted word is the start address, of which the low ADDR_W bits (default 24) are used. The following `length` accepted words are data.
- R4: The data words of a section are written in order, one write per word, to start, start+1, and so on. The address wraps modulo 2^ADDR_W.
- R5: A write appears on the port in the cycle after its data word is accepted: `wr_en_o` is 1, with that word on `wr_data_o` and its address on `wr_addr_o`.
- R6: While `wr_en_o` and `wr_wait_i` are both 1, `word_ready_o` is 0 and the write stays in place with unchanged address and data. The write completes at the first clock edge where `wr_wait_i` is 0.
- R7: An accepted length word of zero sets `done_o` from the next cycle onward, and it stays set until reset.
- R8: After `done_o` is set, words are still accepted (`word_ready_o` is 1) but cause no write, and `err_o` does not change.
- R9: A write whose address lies in [RSV_BASE, RSV_BASE+RSV_COUNT) sets `err_o` in the same cycle the write appears. The default window is 0x809800 to 0x809801. `err_o` stays set until reset. The write is still issued.
- R10: Any number of sections may follow one another before the terminating zero. Each section starts at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 32 | Incoming stream word |
| word_valid_i | input | 1 | Stream word present |
| word_ready_o | output | 1 | Loader can take a word |
| wr_addr_o | output | 24 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_en_o | output | 1 | Write strobe, held while stalled |
| wr_wait_i | input | 1 | Memory holds the current write |
| done_o | output | 1 | Terminating section seen |
| err_o | output | 1 | A write hit the reserved window |

## Verification
The hardest case to reach is a stalled write that overlaps the arrival of the next word: a data word is waiting with valid high while the previous write is held by `wr_wait_i`. The case is hardest when that next word is the terminating zero, because the stall must release before the zero is taken. The bench drives `wr_wait_i` randomly every cycle and inserts random valid gaps, so these overlaps happen many times per image. A directed section starting just below the reserved window, and another that wraps the top of the address space, cover the error flag and the wrap.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    ST_LENGTH  = 2'd0,
    ST_ADDRESS = 2'd1,
    ST_DATA    = 2'd2,
    ST_DONE    = 2'd3
  } bsl_state_e;

  // true when a lies in [base, base+n)
  function automatic logic bsl_in_window(logic [63:0] a, logic [63:0] base, logic [63:0] n);
    return (a >= base) && (a < base + n);
  endfunction
endpackage

// File: rtl/bsl_hdr_skip.sv
module bsl_hdr_skip #(
  parameter int unsigned SKIP_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic hdr_done_o
);
  generate
    if (SKIP_WORDS == 0) begin : g_none
      assign hdr_done_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(SKIP_WORDS + 1);
      logic [CW-1:0] cnt_q;
      assign hdr_done_o = (cnt_q == CW'(SKIP_WORDS));
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (accept_i && !hdr_done_o) cnt_q <= cnt_q + CW'(1);
      end
      p_skip_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SKIP_WORDS));
    end
  endgenerate
endmodule

// File: rtl/bsl_section_fsm.sv
module bsl_section_fsm
  import bsl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_fire_o,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic              done_o
);
  bsl_state_e        state_q;
  logic [WORD_W-1:0] left_q;
  logic [ADDR_W-1:0] addr_q;

  assign data_fire_o = take_i && (state_q == ST_DATA);
  assign data_addr_o = addr_q;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LENGTH;
      left_q  <= '0;
      addr_q  <= '0;
    end else if (take_i) begin
      case (state_q)
        ST_LENGTH: begin
          if (word_i == '0) state_q <= ST_DONE;
          else begin
            left_q  <= word_i;
            state_q <= ST_ADDRESS;
          end
        end
        ST_ADDRESS: begin
          addr_q  <= word_i[ADDR_W-1:0];
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          addr_q <= addr_q + ADDR_W'(1);
          left_q <= left_q - WORD_W'(1);
          if (left_q == WORD_W'(1)) state_q <= ST_LENGTH;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  p_data_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (left_q != '0));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire_o && left_q != WORD_W'(1)) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/bsl_write_port.sv
module bsl_write_port
  import bsl_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] RSV_BASE  = 24'h809800,
  parameter int unsigned       RSV_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              wr_wait_i,
  output logic              stall_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              err_o
);
  logic hit;
  assign hit     = bsl_in_window(64'(addr_i), 64'(RSV_BASE), 64'(RSV_COUNT));
  assign stall_o = wr_en_o && wr_wait_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      if (fire_i) begin
        wr_en_o   <= 1'b1;
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
        if (hit) err_o <= 1'b1;
      end else if (!wr_wait_i) begin
        wr_en_o <= 1'b0;
      end
    end
  end

  p_hold_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  p_no_fire_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !fire_i);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: rtl/bsl_boot_loader.sv
module bsl_boot_loader #(
  parameter int                WORD_W     = 32,
  parameter int                ADDR_W     = 24,
  parameter int unsigned       SKIP_WORDS = 2,
  parameter logic [ADDR_W-1:0] RSV_BASE   = 24'h809800,
  parameter int unsigned       RSV_COUNT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_en_o,
  input  logic              wr_wait_i,
  output logic              done_o,
  output logic              err_o
);
  logic accept, hdr_done, take, fire, stall;
  logic [ADDR_W-1:0] fire_addr;

  assign word_ready_o = !stall;
  assign accept       = word_valid_i && word_ready_o;
  assign take         = accept && hdr_done;

  bsl_hdr_skip #(.SKIP_WORDS(SKIP_WORDS)) u_skip (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .hdr_done_o(hdr_done));

  bsl_section_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take_i(take), .word_i(word_i),
    .data_fire_o(fire), .data_addr_o(fire_addr), .done_o(done_o));

  bsl_write_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W),
                   .RSV_BASE(RSV_BASE), .RSV_COUNT(RSV_COUNT)) u_wr (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .addr_i(fire_addr), .data_i(word_i),
    .wr_wait_i(wr_wait_i), .stall_o(stall), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .err_o(err_o));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o);
  p_hdr_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_done |-> !wr_en_o);
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_wait_i) |-> !word_ready_o);
endmodule

// File: tb/bsl_boot_loader_tb.sv
module bsl_boot_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [23:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        wr_en_o;
  logic        wr_wait_i = 1'b0;
  logic        done_o, err_o;

  int checks = 0, fails = 0;
  int completed = 0, expected_writes = 0;
  bit wait_on = 1'b0, err_exp = 1'b0;
  logic [23:0] exp_addr;

  always #4 clk = ~clk;

  bsl_boot_loader dut_i (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_en_o(wr_en_o), .wr_wait_i(wr_wait_i), .done_o(done_o), .err_o(err_o));

  function automatic bit rsv_hit(logic [23:0] a);
    return (a == 24'h809800) || (a == 24'h809801);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait driver and completion / stall monitor
  always @(negedge clk) begin
    wr_wait_i = wait_on ? ($urandom_range(0, 2) == 0) : 1'b0;
    #1;
    if (rst_n && wr_en_o) begin
      if (wr_wait_i) chk(!word_ready_o, "R6", 64'(word_ready_o), 64'd0);
      else completed++;
    end
  end

  // kind: 0 header/ignored, 1 length, 2 address, 3 data
  task automatic send(logic [31:0] w, int kind);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk);
    word_i = w; word_valid_i = 1'b1;
    #2;
    while (!word_ready_o) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    word_valid_i = 1'b0;
    if (kind == 3) begin
      err_exp = err_exp | rsv_hit(exp_addr);
      chk(wr_en_o && wr_data_o == w && wr_addr_o == exp_addr, "R5/R4",
          {wr_addr_o, wr_data_o}, {exp_addr, w});
      chk(err_o == err_exp, "R9", 64'(err_o), 64'(err_exp));
      exp_addr = exp_addr + 24'd1;
      expected_writes++;
    end else if (kind == 0) begin
      chk(!wr_en_o, "R2/R8", 64'(wr_en_o), 64'd0);
    end
  endtask

  task automatic section(logic [23:0] start, int len, logic [31:0] tag);
    send(32'(len), 1);
    send({8'hA5, start}, 2);
    exp_addr = start;
    for (int i = 0; i < len; i++) send($urandom() ^ tag, 3);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; err_exp = 1'b0; completed = 0; expected_writes = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!wr_en_o && !done_o && !err_o && word_ready_o, "R1",
        {wr_en_o, done_o, err_o, word_ready_o}, 4'b0001);
  endtask

  task automatic finish_load;
    send(32'd0, 1);
    chk(done_o == 1'b1, "R7", 64'(done_o), 64'd1);
    repeat (4) @(negedge clk);
    chk(completed == expected_writes, "R10", completed, expected_writes);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    // image 1: zero-valued header, random sections, wrap, random stalls
    do_reset();
    wait_on = 1'b1;
    send(32'd0, 0); send(32'd0, 0);
    chk(!done_o, "R2", 64'(done_o), 64'd0);
    for (int s = 0; s < 4; s++)
      section(24'h100000 + 24'($urandom_range(0, 24'h0FFFFF)), $urandom_range(1, 6), 32'(s));
    section(24'hFFFFFE, 4, 32'h77);             // R4 wrap
    finish_load();
    chk(!err_o, "R9", 64'(err_o), 64'd0);
    // R8: words after done are taken and ignored
    for (int i = 0; i < 5; i++) send($urandom(), 0);
    chk(done_o && !err_o && completed == expected_writes, "R8",
        {done_o, err_o}, 2'b10);

    // image 2: reserved window and repeated sections
    do_reset();
    send(32'h8, 0); send(32'h10F8, 0);
    section(24'h8097FF, 1, 32'h1);              // just below window, no error
    chk(!err_o, "R9", 64'(err_o), 64'd0);
    section(24'h8097FF, 2, 32'h2);              // second word lands at 0x809800
    section(24'h809802, 3, 32'h3);
    finish_load();
    chk(err_o, "R9", 64'(err_o), 64'd1);
    for (int i = 0; i < 3; i++) send(32'd5, 0);
    chk(err_o && done_o, "R8", {err_o, done_o}, 2'b11);

    // image 3: many random sections with random stalls
    do_reset();
    send($urandom(), 0); send($urandom(), 0);
    for (int s = 0; s < 12; s++)
      section(24'($urandom_range(0, 24'h7FFFFF)), $urandom_range(1, 9), 32'(s) << 8);
    finish_load();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule